// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block follows the exceptions of an in-order pipeline with five stages: fetch, decode, execute, memory and write-back. Every instruction carries a small status vector and its fetch PC through shadow stage registers that move in step with the main pipeline. Each stage reports the fault causes it detects for the instruction it holds, and those causes are ORed into that instruction's vector as it moves to the next stage. Nothing acts on a fault when it is detected.

The vector is read only when the instruction reaches write-back. A valid instruction with an empty vector is allowed to commit. A valid instruction with any cause set causes a trap. The block picks the cause from the earliest stage, blocks the instruction's own writes, squashes every younger instruction, and pulses a trap request that redirects fetch to the handler. The faulting PC and a 4-bit cause code are held until software acknowledges them. This ordering makes a fault from an older instruction win over an earlier-detected fault from a younger one.

The pipeline advances one stage on every clock. The cause inputs of a stage refer to the instruction that occupies that stage in the current cycle.

Top module: `exc_precise_tracker`

## Requirements
- R1: After synchronous reset, trap_valid, trap_pc, trap_cause and wb_commit are all 0.
- R2: Cause codes are 1 to 3 for a fetch page fault, misaligned fetch and fetch protection fault (if_cause bits 0, 1, 2); 4 for an illegal opcode; 5 for an arithmetic fault; and 6 to 8 for a data page fault, misaligned data access and data protection fault (mem_cause bits 0, 1, 2). 0 means no fault. When one instruction has several causes, the smallest code wins. This ranks earlier stages first, and within a stage the lower bit first.
- R3: A fault is acted on only when its instruction occupies write-back. trap_valid is high for exactly one cycle, in the cycle after that. At the same time trap_pc takes the instruction's fetch PC and trap_cause takes the selected code.
- R4: When an older instruction carries a memory-stage fault and a younger instruction carries a fetch-stage fault detected earlier, the older instruction's fault is the one reported.
- R5: wb_commit is high while a valid instruction with an empty vector occupies write-back. It is low for a faulting instruction.
- R6: Once a trap is taken, every younger instruction in flight, including the one being fetched, is squashed. None of them commits or traps.
- R7: An instruction fetched with if_valid low never commits and never traps, whatever causes are posted for it.
- R8: While a trap is pending (from its pulse until trap_ack), trap_pc and trap_cause hold their values. A faulting instruction that reaches write-back in this period raises no pulse and does not commit. Its fault-free neighbours still commit.
- R9: A one-cycle trap_ack ends the pending state, and the next faulting instruction traps normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_valid | input | 1 | A real instruction is being fetched this cycle |
| if_pc | input | PC_W | Fetch PC of that instruction |
| if_cause | input | 3 | Fetch faults: bit 0 page, bit 1 misaligned, bit 2 protection |
| id_cause | input | 1 | Illegal opcode for the instruction in decode |
| ex_cause | input | 1 | Arithmetic fault for the instruction in execute |
| mem_cause | input | 3 | Data faults: bit 0 page, bit 1 misaligned, bit 2 protection |
| trap_ack | input | 1 | Handler acknowledges the recorded trap |
| wb_commit | output | 1 | Instruction in write-back may write registers or memory |
| trap_valid | output | 1 | One-cycle request to fetch the trap handler |
| trap_pc | output | PC_W | Fetch PC of the faulting instruction |
| trap_cause | output | 4 | Code of the reported cause |

## Verification
The hardest case to reach is two different instructions faulting in different stages in a way that makes the younger one's fault visible first. That needs an older instruction's data fault and a younger instruction's fetch fault posted a few cycles apart, timed against the pipeline position of each instruction. The stimulus table gives causes per instruction slot, and one drive loop routes each cause bit to the stage port in the cycle that instruction occupies that stage. This places several faults in different stages of a burst of five instructions without tracking the timing by hand. Reaching a fault while a trap is still pending takes a second burst run on purpose without an acknowledge.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCAUSE  = 8;
  localparam int CODE_W  = 4;
  localparam int IF_BITS = 3;
  localparam int MEM_BITS = 3;
  // bit positions within the status vector: earlier stage sits lower
  localparam int POS_IF  = 0;
  localparam int POS_ID  = POS_IF + IF_BITS;
  localparam int POS_EX  = POS_ID + 1;
  localparam int POS_MEM = POS_EX + 1;
  typedef logic [NCAUSE-1:0] cvec_t;
  typedef enum logic [CODE_W-1:0] {
    C_NONE = 4'd0, C_IF_PAGE = 4'd1, C_IF_ALIGN = 4'd2, C_IF_PROT = 4'd3,
    C_ILLEGAL = 4'd4, C_ARITH = 4'd5,
    C_D_PAGE = 4'd6, C_D_ALIGN = 4'd7, C_D_PROT = 4'd8
  } cause_e;
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            squash,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  input  cvec_t           in_vec,
  input  cvec_t           post,
  output logic            out_valid,
  output logic [PC_W-1:0] out_pc,
  output cvec_t           out_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pc    <= '0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid & ~squash;
      out_pc    <= in_pc;
      out_vec   <= in_vec | post;
    end
  end

  // R6: a squash leaves this slot empty on the next cycle
  assert_squash_empties_R6: assert property (@(posedge clk) disable iff (rst)
    squash |=> !out_valid);
endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc
  import exc_pkg::*;
(
  input  cvec_t             vec,
  output logic              any,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    code = C_NONE;
    for (int i = NCAUSE - 1; i >= 0; i--) begin
      if (vec[i]) code = CODE_W'(i + 1);
    end
    any = |vec;
  end
endmodule

// File: rtl/exc_trap_capture.sv
module exc_trap_capture
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [PC_W-1:0]   wb_pc,
  input  logic [CODE_W-1:0] code,
  input  logic              ack,
  output logic              pending,
  output logic              trap_valid,
  output logic [PC_W-1:0]   trap_pc,
  output logic [CODE_W-1:0] trap_cause
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      trap_valid <= 1'b0;
      trap_pc    <= '0;
      trap_cause <= '0;
    end else begin
      trap_valid <= take;
      if (take) begin
        pending    <= 1'b1;
        trap_pc    <= wb_pc;
        trap_cause <= code;
      end else if (ack) begin
        pending <= 1'b0;
      end
    end
  end

  // R3: the trap request is a single-cycle pulse
  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> !trap_valid);
  // R8: the record holds while a trap is pending
  assert_record_held_R8: assert property (@(posedge clk) disable iff (rst)
    pending |=> ($stable(trap_pc) && $stable(trap_cause)));
  // R2: a taken trap always carries a real cause code
  assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
    take |-> (code != C_NONE && code <= C_D_PROT));
endmodule

// File: rtl/exc_precise_tracker.sv
module exc_precise_tracker
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              if_valid,
  input  logic [PC_W-1:0]   if_pc,
  input  logic [2:0]        if_cause,
  input  logic              id_cause,
  input  logic              ex_cause,
  input  logic [2:0]        mem_cause,
  input  logic              trap_ack,
  output logic              wb_commit,
  output logic              trap_valid,
  output logic [PC_W-1:0]   trap_pc,
  output logic [CODE_W-1:0] trap_cause
);
  localparam int NREG = 4; // decode, execute, memory, write-back

  logic            s_valid [NREG+1];
  logic [PC_W-1:0] s_pc    [NREG+1];
  cvec_t           s_vec   [NREG+1];
  cvec_t           post    [NREG];

  logic              wb_any, take, pending;
  logic [CODE_W-1:0] wb_code;

  assign s_valid[0] = if_valid;
  assign s_pc[0]    = if_pc;
  assign s_vec[0]   = '0;

  always_comb begin
    for (int k = 0; k < NREG; k++) post[k] = '0;
    post[0][POS_IF +: IF_BITS]   = if_cause;
    post[1][POS_ID]              = id_cause;
    post[2][POS_EX]              = ex_cause;
    post[3][POS_MEM +: MEM_BITS] = mem_cause;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_stage
    exc_stage_reg #(.PC_W(PC_W)) u_reg (
      .clk(clk), .rst(rst), .squash(take),
      .in_valid(s_valid[g]), .in_pc(s_pc[g]), .in_vec(s_vec[g]), .post(post[g]),
      .out_valid(s_valid[g+1]), .out_pc(s_pc[g+1]), .out_vec(s_vec[g+1])
    );
  end

  exc_prio_enc u_enc (.vec(s_vec[NREG]), .any(wb_any), .code(wb_code));

  assign take      = s_valid[NREG] & wb_any & ~pending;
  assign wb_commit = s_valid[NREG] & ~wb_any;

  exc_trap_capture #(.PC_W(PC_W)) u_cap (
    .clk(clk), .rst(rst), .take(take), .wb_pc(s_pc[NREG]), .code(wb_code),
    .ack(trap_ack), .pending(pending), .trap_valid(trap_valid),
    .trap_pc(trap_pc), .trap_cause(trap_cause)
  );

  // R7: a trap is only ever raised by an instruction that was valid in write-back
  assert_trap_from_valid_R7: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> $past(s_valid[NREG]));
  // R6: after a taken trap, write-back holds nothing that could commit
  assert_no_commit_after_take_R6: assert property (@(posedge clk) disable iff (rst)
    take |=> !wb_commit);
  // R5: a committing instruction never raises a trap in the same cycle
  assert_commit_excludes_take_R5: assert property (@(posedge clk) disable iff (rst)
    wb_commit |-> !take);
endmodule

// File: tb/exc_precise_tracker_bench.sv
module exc_precise_tracker_bench;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic if_valid = 1'b0;
  logic [PC_W-1:0] if_pc = '0;
  logic [2:0] if_cause = '0;
  logic id_cause = 1'b0, ex_cause = 1'b0;
  logic [2:0] mem_cause = '0;
  logic trap_ack = 1'b0;
  logic wb_commit, trap_valid;
  logic [PC_W-1:0] trap_pc;
  logic [3:0] trap_cause;

  always #4 clk = ~clk; // 125 MHz

  exc_precise_tracker #(.PC_W(PC_W)) u_exc_precise_tracker (
    .clk(clk), .rst(rst), .if_valid(if_valid), .if_pc(if_pc),
    .if_cause(if_cause), .id_cause(id_cause), .ex_cause(ex_cause),
    .mem_cause(mem_cause), .trap_ack(trap_ack), .wb_commit(wb_commit),
    .trap_valid(trap_valid), .trap_pc(trap_pc), .trap_cause(trap_cause)
  );

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // per-instruction vector byte: b0 if page, b1 if align, b2 if prot,
  // b3 illegal, b4 arith, b5 data page, b6 data align, b7 data prot
  typedef struct packed {
    logic [4:0]  vmask;
    logic [39:0] vecs;   // instruction k in bits [8k+7:8k]
    logic [2:0]  idx;    // 5 = no trap
    logic [3:0]  code;
    logic [2:0]  commits;
  } scn_t;

  localparam int NSCN = 9;
  localparam scn_t SCN [NSCN] = '{
    '{5'h1F, 40'h00_00_00_00_00, 3'd5, 4'd0, 3'd5},
    '{5'h1F, 40'h00_00_08_00_00, 3'd2, 4'd4, 3'd2},
    '{5'h1F, 40'h00_00_00_01_20, 3'd0, 4'd6, 3'd0},
    '{5'h1F, 40'h00_91_00_00_00, 3'd3, 4'd1, 3'd3},
    '{5'h1F, 40'h00_00_00_42_00, 3'd1, 4'd2, 3'd1},
    '{5'h1F, 40'h10_00_00_00_00, 3'd4, 4'd5, 3'd4},
    '{5'h1D, 40'h00_80_00_FF_00, 3'd3, 4'd8, 3'd2},
    '{5'h1F, 40'h00_00_40_00_04, 3'd0, 4'd3, 3'd0},
    '{5'h1F, 40'h00_00_28_00_00, 3'd2, 4'd4, 3'd2}
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_burst(input scn_t s, input logic [31:0] base,
                           output int pulses, output int commits,
                           output logic [31:0] pc, output logic [3:0] code);
    pulses = 0; commits = 0; pc = '0; code = '0;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      if_valid  = (c < 5) ? s.vmask[c] : 1'b0;
      if_pc     = base + 32'(4 * c);
      if_cause  = (c < 5) ? s.vecs[8*c +: 3] : 3'b0;
      id_cause  = (c >= 1 && c < 6) ? s.vecs[8*(c-1) + 3] : 1'b0;
      ex_cause  = (c >= 2 && c < 7) ? s.vecs[8*(c-2) + 4] : 1'b0;
      mem_cause = (c >= 3 && c < 8) ? s.vecs[8*(c-3) + 5 +: 3] : 3'b0;
      @(posedge clk);
      #1;
      if (wb_commit) commits++;
      if (trap_valid) begin
        pulses++;
        pc = trap_pc;
        code = trap_cause;
      end
    end
    @(negedge clk);
    if_valid = 1'b0; if_cause = '0; id_cause = 1'b0; ex_cause = 1'b0; mem_cause = '0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    trap_ack = 1'b1;
    @(negedge clk);
    trap_ack = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      applied++;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    int pulses, commits;
    logic [31:0] pc, base;
    logic [3:0] code;

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(trap_valid == 1'b0, "R1 trap_valid", 32'(trap_valid), 0);
    check(trap_pc == '0, "R1 trap_pc", trap_pc, 0);
    check(trap_cause == '0, "R1 trap_cause", 32'(trap_cause), 0);
    check(wb_commit == 1'b0, "R1 wb_commit", 32'(wb_commit), 0);
    @(negedge clk);
    rst = 1'b0;

    // table: R2 code and priority, R3 timing/pc, R4 older wins, R5 commit,
    // R6 squash of younger, R7 invalid instruction
    for (int s = 0; s < NSCN; s++) begin
      base = 32'h0001_0000 + 32'(s * 256);
      run_burst(SCN[s], base, pulses, commits, pc, code);
      check(commits == int'(SCN[s].commits), "R5/R6/R7 commit count",
            32'(commits), 32'(SCN[s].commits));
      if (SCN[s].idx == 3'd5) begin
        check(pulses == 0, "R3 no trap", 32'(pulses), 0);
      end else begin
        check(pulses == 1, "R3/R6 single trap pulse", 32'(pulses), 1);
        check(pc == base + 32'(4 * SCN[s].idx), "R3/R4 trap_pc",
              pc, base + 32'(4 * SCN[s].idx));
        check(code == SCN[s].code, "R2/R4 trap_cause", 32'(code), 32'(SCN[s].code));
        repeat (3) @(posedge clk);
        #1;
        check(trap_pc == pc && trap_cause == code, "R8 record held",
              trap_pc, pc);
        do_ack();
      end
    end

    // R8: second fault while pending is neither reported nor committed
    run_burst(SCN[1], 32'h0002_0000, pulses, commits, pc, code);
    check(pulses == 1 && pc == 32'h0002_0008, "R8 first trap", pc, 32'h0002_0008);
    run_burst(SCN[1], 32'h0003_0000, pulses, commits, pc, code);
    check(pulses == 0, "R8 no pulse while pending", 32'(pulses), 0);
    check(commits == 4, "R8 faulting instr blocked", 32'(commits), 4);
    check(trap_pc == 32'h0002_0008, "R8 trap_pc kept", trap_pc, 32'h0002_0008);
    check(trap_cause == 4'd4, "R8 trap_cause kept", 32'(trap_cause), 4);

    // R9: acknowledge then a new fault traps
    do_ack();
    run_burst(SCN[5], 32'h0004_0000, pulses, commits, pc, code);
    check(pulses == 1, "R9 trap after ack", 32'(pulses), 1);
    check(pc == 32'h0004_0010 && code == 4'd5, "R9 new record", pc, 32'h0004_0010);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule